// File: doc/BRIEF.md
# Two-Stage Routed Interrupt Controller

This block gathers a vector of system event lines into a small number of host interrupt lines. Each event is conditioned by its own polarity and trigger-type setting. It then sets a pending bit, which is gated by a per-event enable. The gated event is steered to one of ten channels, and each channel is steered to one of ten host outputs. A host output is a level signal. It stays high while some enabled pending event reaches it, provided that both the global enable and that host's enable are on.

Software works through a flat 32-bit register port. The port has an address, a write strobe, write data and combinational read data. Pending and enable state can be changed either by writing bit masks or by writing a single event number to a dedicated set or clear register. For each host there is a read-only winner register that names the most urgent event currently reaching that host. Its top bit flags the case where no event reaches it. A handler typically loops on this register, servicing and clearing events until the flag appears.

Top module: `evroute_intc`

## Requirements
- R1: After reset, all routing fields, pending bits, event enables, host enables and the global enable are 0, every polarity bit is 1, every type bit is 0, `host_irq` is 0, and every winner register reads 0x8000_0000.
- R2: Bit masks act on event e through word e/32, bit e mod 32. A write to 0x080+4w sets the pending bits, a write to 0x0A0+4w clears them, a write to 0x0C0+4w sets the enables and a write to 0x0E0+4w clears them. A 1 bit acts and a 0 bit leaves the state unchanged. Reads at 0x080/0x0A0 return the pending bits, and reads at 0x0C0/0x0E0 return the enables.
- R3: Writing event number n to 0x008 sets its pending bit, to 0x00C clears it, to 0x010 sets its enable, and to 0x014 clears its enable. A number of 64 or more changes nothing.
- R4: The channel of event e is held in word 0x200+4*(e/4), bits (e mod 4)*8+3 down to (e mod 4)*8. The host of channel c uses the same layout in word 0x300+4*(c/4). Only these 4-bit fields are stored, and all other bits read as 0.
- R5: Writing host number h to 0x018 enables host h, and writing it to 0x01C disables it. A number of 10 or more changes nothing. Register 0x004 reads the host-enable mask, and bit 0 of 0x000 is the global enable.
- R6: `host_irq[h]` is 1 exactly when the global enable is 1, host h is enabled, and some event that is both pending and enabled routes to host h.
- R7: The winner register of host h, at 0x400+4h, gives the winning event number in bits 9:0, or 0x8000_0000 if none. The winner is the event in the lowest-numbered channel, and within that channel the lowest-numbered event. The register ignores the global and host enables, and a clear made one cycle earlier is already reflected in it.
- R8: In level mode (type bit 0), the pending bit sets on every clock while the event is active. A clear written while the event is still active therefore has no lasting effect. Once the event has dropped, the pending bit holds until it is cleared.
- R9: In edge mode (type bit 1), the pending bit sets only on a change from inactive to active. It stays set until it is cleared, and after a clear it stays clear while the event remains active.
- R10: With polarity bit 1 an event is active when high. With polarity bit 0 it is active when low. Polarity words are at 0x100+4w and type words at 0x120+4w.
- R11: An event whose channel field is 10 or more, or whose channel's host field is 10 or more, reaches no host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 64 | System event lines |
| reg_addr | input | 11 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| host_irq | output | 10 | Host interrupt lines, level |

## Verification
A hardware pending set and a software clear can both land on the same event in one clock. The hardware set must win. The bench provokes this on purpose: it holds a level source high while it writes that event's number to the clear register. It then repeats the clear after the source has dropped, and checks the status word after each clear. Random traffic also lets line activity collide with index and mask writes. Every such cycle is judged against a cycle model in the bench, through the status words, the winner registers and the host lines.

// File: rtl/evr_pkg.sv
package evr_pkg;

  // word addresses (byte address >> 2)
  localparam int unsigned W_CTRL = 32'h000;
  localparam int unsigned W_HEN  = 32'h001;
  localparam int unsigned W_SSET = 32'h002;
  localparam int unsigned W_SCLR = 32'h003;
  localparam int unsigned W_ESET = 32'h004;
  localparam int unsigned W_ECLR = 32'h005;
  localparam int unsigned W_HSET = 32'h006;
  localparam int unsigned W_HCLR = 32'h007;
  localparam int unsigned W_STS  = 32'h020;
  localparam int unsigned W_SCB  = 32'h028;
  localparam int unsigned W_ESB  = 32'h030;
  localparam int unsigned W_ECB  = 32'h038;
  localparam int unsigned W_POL  = 32'h040;
  localparam int unsigned W_TYP  = 32'h048;
  localparam int unsigned W_CHM  = 32'h080;
  localparam int unsigned W_HMP  = 32'h0C0;
  localparam int unsigned W_PRI  = 32'h100;

  // routing fields: four 8-bit lanes per word
  function automatic int map_word(input int idx);
    return idx / 4;
  endfunction

  function automatic int lane_lsb(input int idx);
    return (idx % 4) * 8;
  endfunction

  // bit masks: 32 events per word
  function automatic int bm_word(input int idx);
    return idx / 32;
  endfunction

endpackage

// File: rtl/evr_event_bank.sv
module evr_event_bank #(
  parameter int NUM_EV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic [NUM_EV-1:0] pol,
  input  logic [NUM_EV-1:0] typ,
  input  logic [NUM_EV-1:0] set_req,
  input  logic [NUM_EV-1:0] clr_req,
  input  logic [NUM_EV-1:0] ena_set,
  input  logic [NUM_EV-1:0] ena_clr,
  output logic [NUM_EV-1:0] status,
  output logic [NUM_EV-1:0] enable,
  output logic [NUM_EV-1:0] hw_set
);

  logic [NUM_EV-1:0] act, act_q;

  assign act    = ~(ev_in ^ pol);
  assign hw_set = (act & ~typ) | (act & ~act_q & typ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      act_q  <= '0;
    end else begin
      status <= (status & ~clr_req) | set_req | hw_set;
      enable <= (enable & ~ena_clr) | ena_set;
      act_q  <= act;
    end
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((status & $past(hw_set)) == $past(hw_set)))
    else $error("hardware set lost"); // R8

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) |=> ((status & $past(status & ~clr_req)) == $past(status & ~clr_req)))
    else $error("pending bit dropped without clear"); // R9

  AST_ENABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_set != '0) |=> ((enable & $past(ena_set)) == $past(ena_set)))
    else $error("enable set lost"); // R2

endmodule

// File: rtl/evr_route_arb.sv
module evr_route_arb #(
  parameter int NUM_EV   = 64,
  parameter int NUM_CH   = 10,
  parameter int NUM_HOST = 10,
  parameter int EV_W     = 6,
  parameter int SEL_W    = 4
) (
  input  logic [NUM_EV-1:0]   pend,
  input  logic [SEL_W-1:0]    ev_ch   [NUM_EV],
  input  logic [SEL_W-1:0]    ch_host [NUM_CH],
  output logic [NUM_HOST-1:0] host_any,
  output logic [EV_W-1:0]     host_evt [NUM_HOST]
);

  logic [NUM_CH-1:0] ch_hit;
  logic [EV_W-1:0]   ch_first [NUM_CH];

  // stage 1: lowest pending event in each channel
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ch_hit[c]   = 1'b0;
      ch_first[c] = '0;
      for (int e = NUM_EV - 1; e >= 0; e--) begin
        if (pend[e] && (ev_ch[e] == SEL_W'(c))) begin
          ch_hit[c]   = 1'b1;
          ch_first[c] = EV_W'(e);
        end
      end
    end
  end

  // stage 2: lowest hit channel feeding each host
  always_comb begin
    for (int h = 0; h < NUM_HOST; h++) begin
      host_any[h] = 1'b0;
      host_evt[h] = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
        if (ch_hit[c] && (ch_host[c] == SEL_W'(h))) begin
          host_any[h] = 1'b1;
          host_evt[h] = ch_first[c];
        end
      end
    end
  end

endmodule

// File: rtl/evroute_intc.sv
module evroute_intc
  import evr_pkg::*;
#(
  parameter int NUM_EV   = 64,
  parameter int NUM_CH   = 10,
  parameter int NUM_HOST = 10,
  parameter int ADDR_W   = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EV-1:0]   ev_in,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_HOST-1:0] host_irq
);

  localparam int EV_W  = $clog2(NUM_EV);
  localparam int HS_W  = $clog2(NUM_HOST);
  localparam int NWORD = (NUM_EV + 31) / 32;
  localparam int EVP   = NWORD * 32;
  localparam int SEL_W = 4;

  logic [31:0] wa;
  assign wa = 32'(reg_addr[ADDR_W-1:2]);

  logic                glb_en;
  logic [NUM_HOST-1:0] hen;
  logic [EVP-1:0]      pol_q, typ_q;
  logic [SEL_W-1:0]    ev_ch   [NUM_EV];
  logic [SEL_W-1:0]    ch_host [NUM_CH];

  // named write events
  logic                ev_idx_ok, host_idx_ok;
  logic [EVP-1:0]      set_bm, clr_bm, eset_bm, eclr_bm;
  logic [NUM_HOST-1:0] hen_set, hen_clr;

  assign ev_idx_ok   = (reg_wdata < 32'(NUM_EV));
  assign host_idx_ok = (reg_wdata < 32'(NUM_HOST));

  always_comb begin
    set_bm  = '0;
    clr_bm  = '0;
    eset_bm = '0;
    eclr_bm = '0;
    hen_set = '0;
    hen_clr = '0;
    if (reg_we) begin
      for (int w = 0; w < NWORD; w++) begin
        if (wa == W_STS + 32'(w)) set_bm[w*32 +: 32]  = reg_wdata;
        if (wa == W_SCB + 32'(w)) clr_bm[w*32 +: 32]  = reg_wdata;
        if (wa == W_ESB + 32'(w)) eset_bm[w*32 +: 32] = reg_wdata;
        if (wa == W_ECB + 32'(w)) eclr_bm[w*32 +: 32] = reg_wdata;
      end
      if (ev_idx_ok) begin
        if (wa == W_SSET) set_bm[reg_wdata[EV_W-1:0]]  = 1'b1;
        if (wa == W_SCLR) clr_bm[reg_wdata[EV_W-1:0]]  = 1'b1;
        if (wa == W_ESET) eset_bm[reg_wdata[EV_W-1:0]] = 1'b1;
        if (wa == W_ECLR) eclr_bm[reg_wdata[EV_W-1:0]] = 1'b1;
      end
      if (host_idx_ok) begin
        if (wa == W_HSET) hen_set[reg_wdata[HS_W-1:0]] = 1'b1;
        if (wa == W_HCLR) hen_clr[reg_wdata[HS_W-1:0]] = 1'b1;
      end
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      hen    <= '0;
      pol_q  <= '1;
      typ_q  <= '0;
      for (int e = 0; e < NUM_EV; e++) ev_ch[e] <= '0;
      for (int c = 0; c < NUM_CH; c++) ch_host[c] <= '0;
    end else begin
      hen <= (hen & ~hen_clr) | hen_set;
      if (reg_we) begin
        if (wa == W_CTRL) glb_en <= reg_wdata[0];
        for (int w = 0; w < NWORD; w++) begin
          if (wa == W_POL + 32'(w)) pol_q[w*32 +: 32] <= reg_wdata;
          if (wa == W_TYP + 32'(w)) typ_q[w*32 +: 32] <= reg_wdata;
        end
        for (int e = 0; e < NUM_EV; e++)
          if (wa == W_CHM + 32'(map_word(e))) ev_ch[e] <= reg_wdata[lane_lsb(e) +: SEL_W];
        for (int c = 0; c < NUM_CH; c++)
          if (wa == W_HMP + 32'(map_word(c))) ch_host[c] <= reg_wdata[lane_lsb(c) +: SEL_W];
      end
    end
  end

  logic [NUM_EV-1:0]   status, enable, hw_set, pend;
  logic [NUM_HOST-1:0] host_any;
  logic [EV_W-1:0]     host_evt [NUM_HOST];

  evr_event_bank #(.NUM_EV(NUM_EV)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_in   (ev_in),
    .pol     (pol_q[NUM_EV-1:0]),
    .typ     (typ_q[NUM_EV-1:0]),
    .set_req (set_bm[NUM_EV-1:0]),
    .clr_req (clr_bm[NUM_EV-1:0]),
    .ena_set (eset_bm[NUM_EV-1:0]),
    .ena_clr (eclr_bm[NUM_EV-1:0]),
    .status  (status),
    .enable  (enable),
    .hw_set  (hw_set)
  );

  assign pend = status & enable;

  evr_route_arb #(
    .NUM_EV(NUM_EV), .NUM_CH(NUM_CH), .NUM_HOST(NUM_HOST), .EV_W(EV_W), .SEL_W(SEL_W)
  ) u_arb (
    .pend     (pend),
    .ev_ch    (ev_ch),
    .ch_host  (ch_host),
    .host_any (host_any),
    .host_evt (host_evt)
  );

  assign host_irq = {NUM_HOST{glb_en}} & hen & host_any;

  // read mux
  logic [EVP-1:0] sts_p, ena_p;
  assign sts_p = EVP'(status);
  assign ena_p = EVP'(enable);

  always_comb begin
    reg_rdata = '0;
    if (wa == W_CTRL) reg_rdata = {31'b0, glb_en};
    if (wa == W_HEN)  reg_rdata = 32'(hen);
    for (int w = 0; w < NWORD; w++) begin
      if (wa == W_STS + 32'(w) || wa == W_SCB + 32'(w)) reg_rdata = sts_p[w*32 +: 32];
      if (wa == W_ESB + 32'(w) || wa == W_ECB + 32'(w)) reg_rdata = ena_p[w*32 +: 32];
      if (wa == W_POL + 32'(w)) reg_rdata = pol_q[w*32 +: 32];
      if (wa == W_TYP + 32'(w)) reg_rdata = typ_q[w*32 +: 32];
    end
    for (int e = 0; e < NUM_EV; e++)
      if (wa == W_CHM + 32'(map_word(e))) reg_rdata[lane_lsb(e) +: SEL_W] = ev_ch[e];
    for (int c = 0; c < NUM_CH; c++)
      if (wa == W_HMP + 32'(map_word(c))) reg_rdata[lane_lsb(c) +: SEL_W] = ch_host[c];
    for (int h = 0; h < NUM_HOST; h++)
      if (wa == W_PRI + 32'(h)) reg_rdata = {~host_any[h], 21'b0, 10'(host_evt[h])};
  end

  // checks across bank, arbiter and register file
  for (genvar h = 0; h < NUM_HOST; h++) begin : g_host_chk
    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      host_any[h] |-> pend[host_evt[h]])
      else $error("winner not pending"); // R7

    AST_WINNER_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
      host_any[h] |-> ((ev_ch[host_evt[h]] < SEL_W'(NUM_CH)) && (ch_host[ev_ch[host_evt[h]]] == SEL_W'(h))))
      else $error("winner not routed to host"); // R11
  end

  AST_IDX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && wa == W_SSET && ev_idx_ok) |=> status[$past(reg_wdata[EV_W-1:0])])
    else $error("index set missed"); // R3

  AST_IDX_ENA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && wa == W_ECLR && ev_idx_ok) |=> !enable[$past(reg_wdata[EV_W-1:0])])
    else $error("index enable clear missed"); // R3

  AST_MAP_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && wa == W_CHM) |=> (ev_ch[1] == $past(reg_wdata[11:8])))
    else $error("map lane misplaced"); // R4

endmodule

// File: tb/evroute_intc_tb_top.sv
`timescale 1ns/100ps
module evroute_intc_tb_top;

  localparam int A_CTRL = 'h000, A_HEN = 'h004, A_SSET = 'h008, A_SCLR = 'h00C;
  localparam int A_ESET = 'h010, A_ECLR = 'h014, A_HSET = 'h018, A_HCLR = 'h01C;
  localparam int A_STS = 'h080, A_SCB = 'h0A0, A_ESB = 'h0C0, A_ECB = 'h0E0;
  localparam int A_POL = 'h100, A_TYP = 'h120, A_CHM = 'h200, A_HMP = 'h300, A_PRI = 'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ev_in = '0;
  logic [10:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  host_irq;

  always #10 clk = ~clk;

  evroute_intc dut_i (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // cycle model
  logic [63:0] m_sts, m_ena, m_pol, m_typ, m_actq;
  logic [3:0]  m_ch [64];
  logic [3:0]  m_hm [10];
  logic [9:0]  m_hen;
  logic        m_glb;

  task automatic model_reset();
    m_sts = '0; m_ena = '0; m_pol = '1; m_typ = '0; m_actq = '0;
    m_hen = '0; m_glb = 0;
    for (int e = 0; e < 64; e++) m_ch[e] = '0;
    for (int c = 0; c < 10; c++) m_hm[c] = '0;
  endtask

  task automatic model_step(input logic [10:0] a, input bit we, input logic [31:0] d);
    logic [63:0] act, hw, sset, sclr, eset, eclr;
    logic [9:0] hs, hc;
    sset = '0; sclr = '0; eset = '0; eclr = '0; hs = '0; hc = '0;
    act = ~(ev_in ^ m_pol);
    for (int e = 0; e < 64; e++) hw[e] = m_typ[e] ? (act[e] & ~m_actq[e]) : act[e];
    if (we) begin
      if (a == A_CTRL) m_glb = d[0];
      if (d < 64) begin
        if (a == A_SSET) sset[d[5:0]] = 1'b1;
        if (a == A_SCLR) sclr[d[5:0]] = 1'b1;
        if (a == A_ESET) eset[d[5:0]] = 1'b1;
        if (a == A_ECLR) eclr[d[5:0]] = 1'b1;
      end
      if (d < 10) begin
        if (a == A_HSET) hs[d[3:0]] = 1'b1;
        if (a == A_HCLR) hc[d[3:0]] = 1'b1;
      end
      for (int w = 0; w < 2; w++) begin
        if (a == A_STS + 4*w) sset[w*32 +: 32] = d;
        if (a == A_SCB + 4*w) sclr[w*32 +: 32] = d;
        if (a == A_ESB + 4*w) eset[w*32 +: 32] = d;
        if (a == A_ECB + 4*w) eclr[w*32 +: 32] = d;
        if (a == A_POL + 4*w) m_pol[w*32 +: 32] = d;
        if (a == A_TYP + 4*w) m_typ[w*32 +: 32] = d;
      end
      for (int e = 0; e < 64; e++) if (a == A_CHM + 4*(e/4)) m_ch[e] = d[(e%4)*8 +: 4];
      for (int c = 0; c < 10; c++) if (a == A_HMP + 4*(c/4)) m_hm[c] = d[(c%4)*8 +: 4];
    end
    m_actq = act;
    m_sts  = (m_sts & ~sclr) | sset | hw;
    m_ena  = (m_ena & ~eclr) | eset;
    m_hen  = (m_hen & ~hc) | hs;
  endtask

  function automatic logic [31:0] exp_pri(input int h);
    logic [31:0] r;
    bit found;
    r = 32'h8000_0000; found = 0;
    for (int c = 0; c < 10; c++)
      for (int e = 0; e < 64; e++)
        if (!found && m_ch[e] == 4'(c) && m_hm[c] == 4'(h) && m_sts[e] && m_ena[e]) begin
          r = 32'(e); found = 1;
        end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = 11'(a);
    #0.5;
    v = reg_rdata;
  endtask

  task automatic tick(input int a, input bit we, input logic [31:0] d);
    reg_addr = 11'(a); reg_we = we; reg_wdata = d;
    @(posedge clk);
    model_step(11'(a), we, d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle();
    tick(A_CTRL, 1'b0, '0);
  endtask

  task automatic check_all();
    logic [31:0] v;
    logic [9:0] eirq;
    for (int h = 0; h < 10; h++) begin
      rd(A_PRI + 4*h, v);
      chk("R7", v, exp_pri(h));
      eirq[h] = m_glb & m_hen[h] & ~exp_pri(h)[31];
    end
    chk("R6", 32'(host_irq), 32'(eirq));
    rd(A_STS, v);     chk("R2", v, m_sts[31:0]);
    rd(A_SCB + 4, v); chk("R2", v, m_sts[63:32]);
    rd(A_ESB, v);     chk("R2", v, m_ena[31:0]);
    rd(A_ECB + 4, v); chk("R2", v, m_ena[63:32]);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_PRI, v);      chk("R1", v, 32'h8000_0000);
    rd(A_PRI + 36, v); chk("R1", v, 32'h8000_0000);
    chk("R1", 32'(host_irq), 32'h0);
    rd(A_POL + 4, v);  chk("R1", v, 32'hFFFF_FFFF);
    rd(A_CHM + 4, v);  chk("R1", v, 32'h0);
    rd(A_CTRL, v);     chk("R1", v, 32'h0);

    // R2 bit masks
    tick(A_STS + 4, 1, 32'h5);       rd(A_STS + 4, v); chk("R2", v, 32'h5);
    tick(A_SCB + 4, 1, 32'h1);       rd(A_STS + 4, v); chk("R2", v, 32'h4);
    tick(A_SCB + 4, 1, 32'h0);       rd(A_SCB + 4, v); chk("R2", v, 32'h4);
    tick(A_ESB, 1, 32'hF0);
    tick(A_ECB, 1, 32'h30);          rd(A_ESB, v);     chk("R2", v, 32'hC0);

    // R3 index registers
    tick(A_SSET, 1, 3);
    tick(A_SSET, 1, 200);            rd(A_STS, v);     chk("R3", v, 32'h8);
    rd(A_STS + 4, v);                chk("R3", v, 32'h4);
    tick(A_ESET, 1, 40);             rd(A_ESB + 4, v); chk("R3", v, 32'h100);
    tick(A_ECLR, 1, 6);              rd(A_ESB, v);     chk("R3", v, 32'h80);
    tick(A_SCLR, 1, 34);             rd(A_STS + 4, v); chk("R3", v, 32'h0);

    // R4 routing field layout
    tick(A_CHM + 4, 1, 32'hFFFF_FF07); rd(A_CHM + 4, v); chk("R4", v, 32'h0F0F_0F07);
    tick(A_CHM + 4, 1, 32'h0);
    tick(A_HMP + 8, 1, 32'h0000_0302); rd(A_HMP + 8, v); chk("R4", v, 32'h0000_0302);

    // R5 host enables
    tick(A_HSET, 1, 9); tick(A_HSET, 1, 2); tick(A_HSET, 1, 12);
    rd(A_HEN, v); chk("R5", v, 32'h204);
    tick(A_HCLR, 1, 9);
    rd(A_HEN, v); chk("R5", v, 32'h004);

    // R6 / R7 routing and priority
    tick(A_SCB, 1, '1); tick(A_SCB + 4, 1, '1);
    tick(A_ESB, 1, '1); tick(A_ESB + 4, 1, '1);
    tick(A_CHM + 8, 1, 32'h0008_0000);   // event 10 -> ch 8
    tick(A_CHM + 20, 1, 32'h0000_0008);  // event 20 -> ch 8
    tick(A_CHM + 12, 1, 32'h0000_0009);  // event 12 -> ch 9
    tick(A_SSET, 1, 20); tick(A_SSET, 1, 10); tick(A_SSET, 1, 12);
    chk("R6", 32'(host_irq), 32'h0);
    rd(A_PRI + 8, v);  chk("R7", v, 32'd10);
    rd(A_PRI + 12, v); chk("R7", v, 32'd12);
    tick(A_CTRL, 1, 1);
    chk("R6", 32'(host_irq), 32'h004);
    tick(A_SCLR, 1, 10);
    rd(A_PRI + 8, v);  chk("R7", v, 32'd20);
    tick(A_HMP, 1, 32'h0000_0002);       // ch 0 -> host 2
    tick(A_SSET, 1, 50);
    rd(A_PRI + 8, v);  chk("R7", v, 32'd50);

    // R11 out-of-range routing
    tick(A_CHM + 48, 1, 32'h000C_0000);  // event 50 -> ch 12
    rd(A_PRI + 8, v);  chk("R11", v, 32'd20);
    tick(A_HMP + 8, 1, 32'h0000_030B);   // ch 8 -> host 11
    rd(A_PRI + 8, v);  chk("R11", v, 32'h8000_0000);
    chk("R11", 32'(host_irq), 32'h0);

    // R8 level: hardware set beats concurrent clear
    ev_in[5] = 1'b1;
    idle();                          rd(A_STS, v); chk("R8", v & 32'h20, 32'h20);
    tick(A_SCLR, 1, 5);              rd(A_STS, v); chk("R8", v & 32'h20, 32'h20);
    ev_in[5] = 1'b0;
    idle();                          rd(A_STS, v); chk("R8", v & 32'h20, 32'h20);
    tick(A_SCLR, 1, 5);              rd(A_STS, v); chk("R8", v & 32'h20, 32'h0);

    // R9 edge mode
    tick(A_TYP, 1, 32'h40);
    ev_in[6] = 1'b1;
    idle();                          rd(A_STS, v); chk("R9", v & 32'h40, 32'h40);
    idle();                          rd(A_STS, v); chk("R9", v & 32'h40, 32'h40);
    tick(A_SCLR, 1, 6);
    idle();                          rd(A_STS, v); chk("R9", v & 32'h40, 32'h0);
    ev_in[6] = 1'b0; idle();
    ev_in[6] = 1'b1; idle();         rd(A_STS, v); chk("R9", v & 32'h40, 32'h40);

    // R10 active-low polarity
    tick(A_POL, 1, ~32'h80);         rd(A_STS, v); chk("R10", v & 32'h80, 32'h0);
    idle();                          rd(A_STS, v); chk("R10", v & 32'h80, 32'h80);
    ev_in[7] = 1'b1;
    tick(A_SCLR, 1, 7);              rd(A_STS, v); chk("R10", v & 32'h80, 32'h0);

    check_all();

    // random traffic against the model
    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [31:0] d;
      if ($urandom % 3 == 0) ev_in[$urandom % 64] = $urandom % 2;
      op = $urandom % 12;
      d = 0;
      case (op)
        0:  tick(A_SSET, 1, $urandom % 72);
        1:  tick(A_SCLR, 1, $urandom % 72);
        2:  tick(A_ESET, 1, $urandom % 72);
        3:  tick(A_ECLR, 1, $urandom % 72);
        4: begin
          for (int l = 0; l < 4; l++) d[l*8 +: 4] = 4'($urandom % 12);
          tick(A_CHM + 4*($urandom % 16), 1, d);
        end
        5: begin
          for (int l = 0; l < 4; l++) d[l*8 +: 4] = 4'($urandom % 12);
          tick(A_HMP + 4*($urandom % 3), 1, d);
        end
        6:  tick(A_HSET, 1, $urandom % 12);
        7:  tick(A_HCLR, 1, $urandom % 12);
        8:  tick(($urandom % 2) ? A_POL + 4*($urandom % 2) : A_TYP + 4*($urandom % 2), 1, $urandom);
        9:  tick(A_SCB + 4*($urandom % 2), 1, $urandom);
        10: tick(A_CTRL, 1, ($urandom % 4) != 0);
        default: idle();
      endcase
      check_all();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule